// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch status of every hardware thread in a multithreaded instruction front end. For each thread it keeps four sticky stall flags, one for each downstream stage (decode, rename, execute, commit), the current status code, the fetch PC as loaded by squashes, and a request tag for the instruction cache. Each cycle it resolves squash, stall, release and cache events for every thread with a fixed priority. It also reports a single stage-active flag for the fetch stage as a whole.

Line requests leave through a one-cycle offer: `req_valid` with `req_tid` and `req_tag`, answered in the same cycle by `req_ready`. A low `req_ready` is a refusal, not back-pressure. The offer is not held. Instead the thread is parked in the one shared retry slot, and new requests stop until the `retry` strobe resends the parked request. Responses (`rsp_valid`, `rsp_tid`, `rsp_tag`) are always consumed. A response that does not match a waiting thread's tag is dropped and flagged on `stale_rsp`.

The fetch selector outside the block picks a thread with `sel_valid`/`sel_tid`. Downstream stages drive the block and unblock strobes, commit and decode drive the squash strobes, and commit drives the interrupt inputs.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Status codes are Running=0, Idle=1, Squashing=2, Blocked=3, WaitResponse=4, WaitRetry=5, AccessComplete=6, TrapPending=7, QuiescePending=8. After reset every thread is Running with PC 0 and tag 0, `cache_blocked` is 0, `stage_active` is 1, and no request is offered.
- R2: Flag bit `t*4+s` of `stall_set`/`stall_clr` (s: decode 0, rename 1, execute 2, commit 3) sets or clears a sticky flag; set wins when both are high. If any flag of the thread (after this cycle's strobes) or `ctx_switch` is high, a thread not in WaitResponse becomes Blocked. A thread in WaitResponse keeps waiting.
- R3: A commit squash has top priority: the thread becomes Squashing and its PC takes its `cmt_pc` lane.
- R4: With no commit squash, `rob_squashing` keeps the thread in Squashing, leaves its PC unchanged, and overrides a decode squash.
- R5: A decode squash moves the thread to Squashing and loads its `dec_pc` lane, unless the thread is already Squashing. In that case it is ignored.
- R6: A Blocked or Squashing thread with no squash or stall this cycle returns to Running.
- R7: A selected Running thread with no higher-priority event offers a request carrying its tag. With `req_ready` high it goes to WaitResponse.
- R8: A refused new request puts the thread in WaitRetry, records it in the retry slot and sets `cache_blocked`. No new request is offered while `cache_blocked` is high.
- R9: On `retry`, a slot owner still in WaitRetry resends. If accepted, it goes to WaitResponse and both the slot and `cache_blocked` clear. If refused again, nothing changes. If the owner has left WaitRetry, or the slot is empty, the slot and `cache_blocked` clear.
- R10: A response is accepted only when `rsp_tid`'s thread is in WaitResponse and `rsp_tag` equals its tag. It then goes to Blocked if stalled, otherwise to AccessComplete. Any other response raises `stale_rsp` and changes no state. A thread's tag increments whenever it leaves WaitResponse.
- R11: An AccessComplete thread becomes Running when it is next selected.
- R12: A commit squash, or an acted decode squash, of the slot owner clears the slot and `cache_blocked`.
- R13: `stage_active` updates only on cycles where some thread's status changes. It then becomes 1 if any thread will be Running, Squashing or AccessComplete, and 0 otherwise.
- R14: No new request is offered while `intr_pending` is high and `priv_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_set | input | NT*4 | Per-thread, per-stage block strobes |
| stall_clr | input | NT*4 | Per-thread, per-stage unblock strobes |
| ctx_switch | input | 1 | Context switch in progress, stalls all threads |
| cmt_squash | input | NT | Commit squash strobe per thread |
| cmt_pc | input | NT*PC_W | Redirect PC per thread from commit |
| rob_squashing | input | NT | Reorder buffer still squashing, per thread |
| dec_squash | input | NT | Decode squash strobe per thread |
| dec_pc | input | NT*PC_W | Redirect PC per thread from decode |
| intr_pending | input | 1 | Interrupt pending |
| priv_mode | input | 1 | Privileged mode, lets fetch proceed under interrupt |
| sel_valid | input | 1 | A thread is selected for fetch this cycle |
| sel_tid | input | TID_W | Selected thread |
| req_valid | output | 1 | Line request offered this cycle |
| req_ready | input | 1 | Cache accepts the offered request |
| req_tid | output | TID_W | Thread of the offered request |
| req_tag | output | TAG_W | Tag of the offered request |
| rsp_valid | input | 1 | Cache response strobe |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_tag | input | TAG_W | Tag of the response |
| retry | input | 1 | Cache can take the parked request again |
| thread_state | output | NT*4 | Status code per thread |
| thread_pc | output | NT*PC_W | Fetch PC per thread |
| cache_blocked | output | 1 | New line requests are held off |
| stale_rsp | output | 1 | Current response was discarded |
| stage_active | output | 1 | Fetch stage is active |

## Verification
A wrong status shows on `thread_state` at the next clock edge. Its effects continue afterwards: a thread stuck in WaitRetry or holding the slot keeps `cache_blocked` high and suppresses every later `req_valid`. A tag that fails to advance shows the first time a stale response arrives: a response that should raise `stale_rsp` is accepted instead and moves the thread to AccessComplete in the following cycle. A mis-resolved priority between squash sources shows as a wrong value on `thread_pc` one cycle after the strobes. The bench drives directed sequences for each priority rule and the retry slot, then long random traffic, and compares every output with a behavioural model every cycle.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    TS_RUN     = 4'd0,
    TS_IDLE    = 4'd1,
    TS_SQUASH  = 4'd2,
    TS_BLOCK   = 4'd3,
    TS_WRESP   = 4'd4,
    TS_WRETRY  = 4'd5,
    TS_DONE    = 4'd6,
    TS_TRAP    = 4'd7,
    TS_QUIESCE = 4'd8
  } tstate_e;

  function automatic logic keeps_stage_busy(tstate_e s);
    return (s == TS_RUN) || (s == TS_SQUASH) || (s == TS_DONE);
  endfunction
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
  parameter int NT     = 2,
  parameter int NSTAGE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NT*NSTAGE-1:0] set_i,
  input  logic [NT*NSTAGE-1:0] clr_i,
  input  logic                 ctx_i,
  output logic [NT-1:0]        stall_o
);
  localparam int NF = NT * NSTAGE;

  logic [NF-1:0] fl_q;
  logic [NF-1:0] fl_n;

  assign fl_n = set_i | (fl_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_n;
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign stall_o[t] = ctx_i | (|fl_n[t*NSTAGE +: NSTAGE]);
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_q ^ $past(fl_q)) & ~$past(set_i | clr_i)) == '0); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((fl_q & $past(set_i)) == $past(set_i))); // R2
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             cmt_sq_i,
  input  logic [PC_W-1:0]  cmt_pc_i,
  input  logic             rob_sq_i,
  input  logic             dec_sq_i,
  input  logic [PC_W-1:0]  dec_pc_i,
  input  logic             rsp_here_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  input  logic             sel_i,
  input  logic             issue_ok_i,
  input  logic             ready_i,
  input  logic             retry_go_i,
  output tstate_e          st_o,
  output tstate_e          st_n_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             offer_o,
  output logic             fresh_o,
  output logic             squashed_o,
  output logic             hit_o
);
  tstate_e          st_q, st_n;
  logic [PC_W-1:0]  pc_q, pc_n;
  logic [TAG_W-1:0] tag_q;
  logic             dec_acts;

  assign hit_o    = rsp_here_i && (st_q == TS_WRESP) && (rsp_tag_i == tag_q);
  assign dec_acts = dec_sq_i && (st_q != TS_SQUASH);

  always_comb begin
    st_n       = st_q;
    pc_n       = pc_q;
    offer_o    = 1'b0;
    fresh_o    = 1'b0;
    squashed_o = 1'b0;
    if (cmt_sq_i) begin
      st_n       = TS_SQUASH;
      pc_n       = cmt_pc_i;
      squashed_o = 1'b1;
    end else if (rob_sq_i) begin
      st_n = TS_SQUASH;
    end else if (dec_acts) begin
      st_n       = TS_SQUASH;
      pc_n       = dec_pc_i;
      squashed_o = 1'b1;
    end else if (stall_i && st_q != TS_WRESP) begin
      st_n = TS_BLOCK;
    end else if (st_q == TS_BLOCK || st_q == TS_SQUASH) begin
      st_n = TS_RUN;
    end else begin
      unique case (st_q)
        TS_WRESP:  if (hit_o) st_n = stall_i ? TS_BLOCK : TS_DONE;
        TS_DONE:   if (sel_i) st_n = TS_RUN;
        TS_RUN: if (sel_i && issue_ok_i) begin
          offer_o = 1'b1;
          fresh_o = 1'b1;
          st_n    = ready_i ? TS_WRESP : TS_WRETRY;
        end
        TS_WRETRY: if (retry_go_i) begin
          offer_o = 1'b1;
          st_n    = ready_i ? TS_WRESP : TS_WRETRY;
        end
        default: st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TS_RUN;
      pc_q  <= '0;
      tag_q <= '0;
    end else begin
      st_q <= st_n;
      pc_q <= pc_n;
      if (st_q == TS_WRESP && st_n != TS_WRESP) tag_q <= tag_q + 1'b1;
    end
  end

  assign st_o   = st_q;
  assign st_n_o = st_n;
  assign pc_o   = pc_q;
  assign tag_o  = tag_q;

  AST_CMT_SQUASH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_sq_i |=> (st_q == TS_SQUASH && pc_q == $past(cmt_pc_i))); // R3
  AST_ROB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_sq_i && rob_sq_i) |=> (st_q == TS_SQUASH && $stable(pc_q))); // R4
  AST_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_sq_i && dec_sq_i && st_q == TS_SQUASH) |=> $stable(pc_q)); // R5
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_BLOCK && !stall_i && !cmt_sq_i && !rob_sq_i && !dec_sq_i)
      |=> st_q == TS_RUN); // R6
  AST_WAIT_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_WRESP && !cmt_sq_i && !rob_sq_i && !dec_sq_i && !hit_o)
      |=> (st_q == TS_WRESP && $stable(tag_q))); // R2
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NT     = 2,
  parameter int NSTAGE = 4,
  parameter int PC_W   = 16,
  parameter int TAG_W  = 3,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NT*NSTAGE-1:0] stall_set,
  input  logic [NT*NSTAGE-1:0] stall_clr,
  input  logic                 ctx_switch,
  input  logic [NT-1:0]        cmt_squash,
  input  logic [NT*PC_W-1:0]   cmt_pc,
  input  logic [NT-1:0]        rob_squashing,
  input  logic [NT-1:0]        dec_squash,
  input  logic [NT*PC_W-1:0]   dec_pc,
  input  logic                 intr_pending,
  input  logic                 priv_mode,
  input  logic                 sel_valid,
  input  logic [TID_W-1:0]     sel_tid,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [TID_W-1:0]     req_tid,
  output logic [TAG_W-1:0]     req_tag,
  input  logic                 rsp_valid,
  input  logic [TID_W-1:0]     rsp_tid,
  input  logic [TAG_W-1:0]     rsp_tag,
  input  logic                 retry,
  output logic [NT*ST_W-1:0]   thread_state,
  output logic [NT*PC_W-1:0]   thread_pc,
  output logic                 cache_blocked,
  output logic                 stale_rsp,
  output logic                 stage_active
);
  logic [NT-1:0]    stall, offer, fresh, squashed, hit, chg, busy_n, in_retry;
  logic [TAG_W-1:0] tags [NT];
  tstate_e          st [NT];
  tstate_e          st_n [NT];
  logic             slot_v;
  logic [TID_W-1:0] slot_t;
  logic             blk_q, act_q, issue_ok, refused_new;

  assign issue_ok = !blk_q && !(intr_pending && !priv_mode);

  fsc_stall_flags #(.NT(NT), .NSTAGE(NSTAGE)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(stall_set), .clr_i(stall_clr),
    .ctx_i(ctx_switch), .stall_o(stall)
  );

  for (genvar t = 0; t < NT; t++) begin : g_thr
    fsc_thread_fsm #(.PC_W(PC_W), .TAG_W(TAG_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .stall_i(stall[t]),
      .cmt_sq_i(cmt_squash[t]), .cmt_pc_i(cmt_pc[t*PC_W +: PC_W]),
      .rob_sq_i(rob_squashing[t]),
      .dec_sq_i(dec_squash[t]), .dec_pc_i(dec_pc[t*PC_W +: PC_W]),
      .rsp_here_i(rsp_valid && rsp_tid == TID_W'(t)), .rsp_tag_i(rsp_tag),
      .sel_i(sel_valid && sel_tid == TID_W'(t)),
      .issue_ok_i(issue_ok), .ready_i(req_ready),
      .retry_go_i(retry && slot_v && slot_t == TID_W'(t)),
      .st_o(st[t]), .st_n_o(st_n[t]), .pc_o(thread_pc[t*PC_W +: PC_W]),
      .tag_o(tags[t]), .offer_o(offer[t]), .fresh_o(fresh[t]),
      .squashed_o(squashed[t]), .hit_o(hit[t])
    );
    assign thread_state[t*ST_W +: ST_W] = st[t];
    assign chg[t]      = (st_n[t] != st[t]);
    assign busy_n[t]   = keeps_stage_busy(st_n[t]);
    assign in_retry[t] = (st[t] == TS_WRETRY);
  end

  always_comb begin
    req_tid = '0;
    req_tag = '0;
    for (int t = 0; t < NT; t++) begin
      if (offer[t]) begin
        req_tid = TID_W'(t);
        req_tag = tags[t];
      end
    end
  end

  assign req_valid     = |offer;
  assign refused_new   = |(offer & fresh) && !req_ready;
  assign stale_rsp     = rsp_valid && !(|hit);
  assign cache_blocked = blk_q;
  assign stage_active  = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v <= 1'b0;
      slot_t <= '0;
      blk_q  <= 1'b0;
    end else if (refused_new) begin
      slot_v <= 1'b1;
      slot_t <= req_tid;
      blk_q  <= 1'b1;
    end else if (slot_v && squashed[slot_t]) begin
      slot_v <= 1'b0;
      blk_q  <= 1'b0;
    end else if (retry) begin
      if (!slot_v || !(offer[slot_t] && !req_ready)) begin
        slot_v <= 1'b0;
        blk_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    act_q <= 1'b1;
    else if (|chg) act_q <= |busy_n;
  end

  AST_SLOT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_v |-> blk_q); // R8
  AST_NO_FRESH_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !slot_v) |-> !blk_q); // R8
  AST_ONE_RETRY_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_retry) <= 1); // R9
  AST_ONE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(offer)); // R7
  AST_INTR_WITHHOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_pending && !priv_mode && !slot_v) |-> !req_valid); // R14
endmodule

// File: tb/sim_fetch_status_ctrl.sv
module sim_fetch_status_ctrl;
  localparam int CLK_P = 10;
  localparam int NT = 2, NS = 4, PW = 16, TW = 3;

  logic clk = 0, rst_n = 0;
  logic [NT*NS-1:0] stall_set, stall_clr;
  logic ctx_switch, intr_pending, priv_mode, sel_valid, req_ready, rsp_valid, retry;
  logic [NT-1:0] cmt_squash, rob_squashing, dec_squash;
  logic [NT*PW-1:0] cmt_pc, dec_pc;
  logic [0:0] sel_tid, rsp_tid, req_tid;
  logic [TW-1:0] rsp_tag, req_tag;
  logic req_valid, cache_blocked, stale_rsp, stage_active;
  logic [NT*4-1:0] thread_state;
  logic [NT*PW-1:0] thread_pc;

  always #(CLK_P/2) clk = ~clk;

  fetch_status_ctrl #(.NT(NT), .NSTAGE(NS), .PC_W(PW), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_set(stall_set), .stall_clr(stall_clr),
    .ctx_switch(ctx_switch), .cmt_squash(cmt_squash), .cmt_pc(cmt_pc),
    .rob_squashing(rob_squashing), .dec_squash(dec_squash), .dec_pc(dec_pc),
    .intr_pending(intr_pending), .priv_mode(priv_mode), .sel_valid(sel_valid),
    .sel_tid(sel_tid), .req_valid(req_valid), .req_ready(req_ready),
    .req_tid(req_tid), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_tid(rsp_tid), .rsp_tag(rsp_tag), .retry(retry),
    .thread_state(thread_state), .thread_pc(thread_pc),
    .cache_blocked(cache_blocked), .stale_rsp(stale_rsp),
    .stage_active(stage_active)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int mst[NT], mtag[NT], nst[NT], ntag[NT];
  int mpc[NT], npc[NT];
  bit mfl[NT][NS], nfl[NT][NS];
  bit sq[NT], off[NT];
  bit mslot_v, nslot_v, mblk, nblk, mact, nact;
  int mslot_t, nslot_t;
  bit e_req_valid, e_stale;
  int e_req_tid, e_req_tag;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clr_in();
    stall_set = '0; stall_clr = '0; ctx_switch = 0; cmt_squash = '0; cmt_pc = '0;
    rob_squashing = '0; dec_squash = '0; dec_pc = '0; intr_pending = 0;
    priv_mode = 0; sel_valid = 0; sel_tid = 0; req_ready = 1; rsp_valid = 0;
    rsp_tid = 0; rsp_tag = 0; retry = 0;
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      mst[t] = 0; mtag[t] = 0; mpc[t] = 0;
      for (int s = 0; s < NS; s++) mfl[t][s] = 0;
    end
    mslot_v = 0; mslot_t = 0; mblk = 0; mact = 1;
  endtask

  task automatic model_eval();
    bit any_hit, refused, chg, busy;
    bit stall, hit, sel, ok;
    any_hit = 0; refused = 0;
    e_req_valid = 0; e_req_tid = 0; e_req_tag = 0;
    ok = !mblk && !(intr_pending && !priv_mode);
    for (int t = 0; t < NT; t++) begin
      stall = ctx_switch;
      for (int s = 0; s < NS; s++) begin
        if (stall_set[t*NS+s]) nfl[t][s] = 1;
        else if (stall_clr[t*NS+s]) nfl[t][s] = 0;
        else nfl[t][s] = mfl[t][s];
        if (nfl[t][s]) stall = 1;
      end
      hit = rsp_valid && rsp_tid == t && mst[t] == 4 && mtag[t] == rsp_tag;
      if (hit) any_hit = 1;
      sel = sel_valid && sel_tid == t;
      nst[t] = mst[t]; npc[t] = mpc[t]; sq[t] = 0; off[t] = 0;
      if (cmt_squash[t]) begin nst[t] = 2; npc[t] = cmt_pc[t*PW +: PW]; sq[t] = 1; end
      else if (rob_squashing[t]) nst[t] = 2;
      else if (dec_squash[t] && mst[t] != 2) begin nst[t] = 2; npc[t] = dec_pc[t*PW +: PW]; sq[t] = 1; end
      else if (stall && mst[t] != 4) nst[t] = 3;
      else if (mst[t] == 3 || mst[t] == 2) nst[t] = 0;
      else if (mst[t] == 4) begin if (hit) nst[t] = stall ? 3 : 6; end
      else if (mst[t] == 6) begin if (sel) nst[t] = 0; end
      else if (mst[t] == 0) begin
        if (sel && ok) begin
          off[t] = 1; nst[t] = req_ready ? 4 : 5;
          if (!req_ready) refused = 1;
        end
      end else if (mst[t] == 5) begin
        if (retry && mslot_v && mslot_t == t) begin off[t] = 1; nst[t] = req_ready ? 4 : 5; end
      end
      ntag[t] = (mst[t] == 4 && nst[t] != 4) ? (mtag[t] + 1) % 8 : mtag[t];
      if (off[t]) begin e_req_valid = 1; e_req_tid = t; e_req_tag = mtag[t]; end
    end
    e_stale = rsp_valid && !any_hit;
    nslot_v = mslot_v; nslot_t = mslot_t; nblk = mblk;
    if (refused) begin nslot_v = 1; nslot_t = e_req_tid; nblk = 1; end
    else if (mslot_v && sq[mslot_t]) begin nslot_v = 0; nblk = 0; end
    else if (retry) begin
      if (!mslot_v || !(off[mslot_t] && !req_ready)) begin nslot_v = 0; nblk = 0; end
    end
    chg = 0; busy = 0;
    for (int t = 0; t < NT; t++) begin
      if (nst[t] != mst[t]) chg = 1;
      if (nst[t] == 0 || nst[t] == 2 || nst[t] == 6) busy = 1;
    end
    nact = chg ? busy : mact;
  endtask

  task automatic model_commit();
    for (int t = 0; t < NT; t++) begin
      mst[t] = nst[t]; mpc[t] = npc[t]; mtag[t] = ntag[t];
      for (int s = 0; s < NS; s++) mfl[t][s] = nfl[t][s];
    end
    mslot_v = nslot_v; mslot_t = nslot_t; mblk = nblk; mact = nact;
  endtask

  task automatic cmp_regs();
    for (int t = 0; t < NT; t++) begin
      chk(cur_req, $sformatf("state[%0d]", t), int'(thread_state[t*4 +: 4]), mst[t]);
      chk(cur_req, $sformatf("pc[%0d]", t), int'(thread_pc[t*PW +: PW]), mpc[t]);
    end
    chk(cur_req, "cache_blocked", int'(cache_blocked), int'(mblk));
    chk(cur_req, "stage_active", int'(stage_active), int'(mact));
  endtask

  task automatic cyc();
    #1;
    model_eval();
    chk(cur_req, "req_valid", int'(req_valid), int'(e_req_valid));
    if (e_req_valid) begin
      chk(cur_req, "req_tid", int'(req_tid), e_req_tid);
      chk(cur_req, "req_tag", int'(req_tag), e_req_tag);
    end
    chk(cur_req, "stale_rsp", int'(stale_rsp), int'(e_stale));
    @(posedge clk);
    model_commit();
    @(negedge clk);
    cmp_regs();
    clr_in();
  endtask

  initial begin
    #(CLK_P*150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_in();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    #1;
    cmp_regs();
    chk("R1", "req_valid at reset", int'(req_valid), 0);
    // R7: issue for thread 0, accepted
    cur_req = "R7"; sel_valid = 1; sel_tid = 0; cyc();
    chk("R7", "t0 waits", int'(thread_state[3:0]), 4);
    // R10: stale tag, then matching tag
    cur_req = "R10"; rsp_valid = 1; rsp_tid = 0; rsp_tag = 3'd5; cyc();
    rsp_valid = 1; rsp_tid = 0; rsp_tag = 3'd0; cyc();
    chk("R10", "t0 access complete", int'(thread_state[3:0]), 6);
    // R11
    cur_req = "R11"; sel_valid = 1; sel_tid = 0; cyc();
    chk("R11", "t0 running", int'(thread_state[3:0]), 0);
    // R8: refusal on thread 1, then blocked issue of thread 0
    cur_req = "R8"; sel_valid = 1; sel_tid = 1; req_ready = 0; cyc();
    chk("R8", "t1 wait retry", int'(thread_state[7:4]), 5);
    sel_valid = 1; sel_tid = 0; cyc();
    // R9: retry refused, then accepted
    cur_req = "R9"; retry = 1; req_ready = 0; cyc();
    retry = 1; req_ready = 1; cyc();
    chk("R9", "cache unblocked", int'(cache_blocked), 0);
    // R2: stall sticky, wait exemption
    cur_req = "R2"; stall_set[0*NS+1] = 1; cyc();
    cyc();
    chk("R2", "t0 stays blocked", int'(thread_state[3:0]), 3);
    // R10: response to stalled waiting thread 1 goes to Blocked
    cur_req = "R10"; ctx_switch = 1; rsp_valid = 1; rsp_tid = 1; rsp_tag = 3'd0; cyc();
    // R6: release
    cur_req = "R6"; stall_clr[0*NS+1] = 1; cyc();
    cyc();
    // R3 and priority over decode
    cur_req = "R3"; cmt_squash = 2'b01; cmt_pc[15:0] = 16'h1234;
    dec_squash = 2'b01; dec_pc[15:0] = 16'h5555; cyc();
    chk("R3", "t0 pc", int'(thread_pc[15:0]), 16'h1234);
    // R4
    cur_req = "R4"; rob_squashing = 2'b01; dec_squash = 2'b01; dec_pc[15:0] = 16'h7777; cyc();
    // R5: ignored while squashing, then acted
    cur_req = "R5"; dec_squash = 2'b01; dec_pc[15:0] = 16'h4444; cyc();
    chk("R5", "t0 pc kept", int'(thread_pc[15:0]), 16'h1234);
    cyc();
    dec_squash = 2'b01; dec_pc[15:0] = 16'h2468; cyc();
    chk("R5", "t0 pc decode", int'(thread_pc[15:0]), 16'h2468);
    cyc();
    // R12: slot owner squash frees slot
    cur_req = "R12"; sel_valid = 1; sel_tid = 1; req_ready = 0; cyc();
    cmt_squash = 2'b10; cmt_pc[31:16] = 16'h00aa; cyc();
    chk("R12", "cache unblocked", int'(cache_blocked), 0);
    cyc();
    // R14
    cur_req = "R14"; intr_pending = 1; sel_valid = 1; sel_tid = 0; cyc();
    intr_pending = 1; priv_mode = 1; sel_valid = 1; sel_tid = 0; cyc();
    // R13: both waiting -> inactive
    cur_req = "R13"; sel_valid = 1; sel_tid = 1; cyc();
    chk("R13", "stage idle", int'(stage_active), 0);
    // random traffic
    cur_req = "R13";
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < NT*NS; b++) begin
        stall_set[b] = ($urandom_range(0, 40) == 0);
        stall_clr[b] = ($urandom_range(0, 6) == 0);
      end
      ctx_switch = ($urandom_range(0, 40) == 0);
      for (int t = 0; t < NT; t++) begin
        cmt_squash[t] = ($urandom_range(0, 30) == 0);
        rob_squashing[t] = ($urandom_range(0, 30) == 0);
        dec_squash[t] = ($urandom_range(0, 15) == 0);
        cmt_pc[t*PW +: PW] = PW'($urandom);
        dec_pc[t*PW +: PW] = PW'($urandom);
      end
      intr_pending = ($urandom_range(0, 7) == 0);
      priv_mode = $urandom_range(0, 1) == 1;
      sel_valid = $urandom_range(0, 1) == 1;
      sel_tid = 1'($urandom_range(0, 1));
      req_ready = ($urandom_range(0, 3) != 0);
      rsp_valid = ($urandom_range(0, 2) == 0);
      rsp_tid = 1'($urandom_range(0, 1));
      rsp_tag = ($urandom_range(0, 1) == 0) ? TW'(mtag[rsp_tid]) : TW'($urandom);
      retry = ($urandom_range(0, 5) == 0);
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule